// File: doc/BRIEF.md
# SYSREF Delay Sweep Calibrator

This controller finds a safe setting for the delay that a high-speed converter applies to its continuously running SYSREF input. It drives a simple register master port into the converter. For each delay code in turn, it runs a fixed trial: it stops SYSREF processing, programs the code, optionally resets the serial-link core, clears the sticky status flags, restarts processing, waits, and reads the flags back. Each code is recorded as passing or failing in a bitmap.

When the sweep is over, the controller picks the centre of the longest unbroken run of passing codes. It programs that code and only then raises a link-enable output, which lets the downstream serial-link receiver come up. The receiver does not need to be running while the sweep is in progress. Failing codes drift with temperature and with clock-to-SYSREF timing, so software can repeat the sweep at any time with a new start pulse.

Converter register map used by the controller (all defaults are parameters):
- control register 0x060: write 0x00 to stop processing and 0x01 to start it;
- delay register 0x061: holds the code in its low bits;
- flag register 0x06C: read it to get the flags; write 0x07 to clear bits 0 to 2;
- link-core reset register 0x201.

Top module: `sref_cal_ctl`

## Requirements
- R1: Each trial issues, in this order: a write of 0x00 to 0x060, a write of the code to 0x061, a write of 0x07 to 0x06C, a write of 0x01 to 0x060, and a read of 0x06C. The delay register is never written while processing is on.
- R2: When `link_rst_en` is high at the start pulse, every trial inserts two writes to 0x201 right after the delay write: first 0x3E, then 0x3F. When it is low at the start pulse, no trial writes 0x201. Changes to `link_rst_en` during a run have no effect.
- R3: The flag read of a trial is not requested until at least SETTLE_CYC (default 16) cycles after the handshake of that trial's processing-on write.
- R4: A code fails if flag bit 0 (dirty capture) is set. In link-reset mode, it also fails if bit 2 (realigned) or bit 3 (sync lost) is set. Outside link-reset mode, bits 2 and 3 are ignored.
- R5: Codes 0 to 7 are tried once each, in ascending order. Bit i of `pass_map` is 1 exactly when code i passed. `pass_map` changes only during a run.
- R6: `chosen_code` is the centre of the longest contiguous run of passing codes. For a run of even length, the lower of the two middle codes is used. Between runs of equal length, the lower run wins. Runs do not wrap from 7 back to 0.
- R7: After the sweep, the controller writes 0x00 to 0x060, then the chosen code to 0x061, then 0x01 to 0x060. `link_en` stays low during every access and rises together with `done` after the last write.
- R8: If no code passes, `no_good` is set, `link_en` stays low, and code 0 is written to the delay register.
- R9: `busy` is high from the cycle after an accepted start until the cycle before `done`. A start pulse while busy is ignored. A start pulse while idle or done clears `pass_map` and the result outputs.
- R10: While reset is asserted, `busy`, `done`, `no_good`, `link_en`, `chosen_code`, `pass_map` and `reg_valid` are all 0.
- R11: Once `reg_valid` is raised, it stays high with address, data and direction stable until `reg_ready`. Only one access is outstanding at a time. Read data is taken on `reg_rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for a calibration run |
| link_rst_en | input | 1 | Selects link-core-reset trials; sampled at start |
| reg_valid | output | 1 | Register access request |
| reg_ready | input | 1 | Converter accepts the request |
| reg_write | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 12 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_rvalid | input | 1 | Read data strobe |
| reg_rdata | input | 8 | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, result valid |
| no_good | output | 1 | No delay code passed |
| link_en | output | 1 | Downstream link receiver may start |
| chosen_code | output | 3 | Final delay code |
| pass_map | output | 8 | Per-code pass bitmap |

## Verification
The bound checker watches the properties that hold on every cycle:
- the request stays stable until accepted;
- there is a minimum settle gap before each flag read;
- `link_en` only ever appears with `done` while idle;
- `no_good` excludes `link_en` and forces code 0;
- the bitmap is frozen outside a run.

The order of the accesses within each trial, the ascending sweep, the failure rules and the choice of the window centre depend on the converter's answers. Only the bench's converter model can show them, with its fault masks per code, sticky flags and order tracker. The same holds for ignoring a start pulse during a run and for restarting cleanly after a run.

// File: rtl/sref_cal_pkg.sv
package sref_cal_pkg;

   // trial and final-programming steps, in issue order
   typedef enum logic [3:0] {
      ST_OFF, ST_DLY, ST_RST0, ST_RST1, ST_CLR, ST_ON, ST_RD,
      ST_FOFF, ST_FDLY, ST_FON
   } step_e;

   typedef enum logic [2:0] {
      C_IDLE, C_ACC, C_SETTLE, C_PICK, C_DONE
   } ctl_e;

   typedef enum logic [1:0] {
      B_IDLE, B_ADDR, B_RDW, B_ACK
   } bus_e;

endpackage

// File: rtl/sref_cal_step.sv
module sref_cal_step
   import sref_cal_pkg::*;
#(
   parameter int CODE_W = 3,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h060,
   parameter logic [ADDR_W-1:0] DLY_ADDR  = 12'h061,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 12'h06C,
   parameter logic [ADDR_W-1:0] LRST_ADDR = 12'h201,
   parameter logic [DATA_W-1:0] LRST_D0   = 8'h3E,
   parameter logic [DATA_W-1:0] LRST_D1   = 8'h3F,
   parameter logic [DATA_W-1:0] FLAG_CLR  = 8'h07,
   parameter logic [DATA_W-1:0] PROC_ON   = 8'h01
) (
   input  step_e              step,
   input  logic [CODE_W-1:0]  trial_code,
   input  logic [CODE_W-1:0]  final_code,
   output logic               wr,
   output logic [ADDR_W-1:0]  addr,
   output logic [DATA_W-1:0]  wdata
);

   always_comb begin
      wr    = 1'b1;
      addr  = CTRL_ADDR;
      wdata = '0;
      unique case (step)
         ST_OFF, ST_FOFF: begin
            addr  = CTRL_ADDR;
            wdata = '0;
         end
         ST_DLY: begin
            addr  = DLY_ADDR;
            wdata = DATA_W'(trial_code);
         end
         ST_FDLY: begin
            addr  = DLY_ADDR;
            wdata = DATA_W'(final_code);
         end
         ST_RST0: begin
            addr  = LRST_ADDR;
            wdata = LRST_D0;
         end
         ST_RST1: begin
            addr  = LRST_ADDR;
            wdata = LRST_D1;
         end
         ST_CLR: begin
            addr  = FLAG_ADDR;
            wdata = FLAG_CLR;
         end
         ST_ON, ST_FON: begin
            addr  = CTRL_ADDR;
            wdata = PROC_ON;
         end
         ST_RD: begin
            wr    = 1'b0;
            addr  = FLAG_ADDR;
            wdata = '0;
         end
         default: begin
            wr    = 1'b1;
            addr  = CTRL_ADDR;
            wdata = '0;
         end
      endcase
   end

endmodule

// File: rtl/sref_cal_bus.sv
module sref_cal_bus
   import sref_cal_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              ack,
   output logic [DATA_W-1:0] rdata_o,
   output logic              reg_valid,
   input  logic              reg_ready,
   output logic              reg_write,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_rvalid,
   input  logic [DATA_W-1:0] reg_rdata
);

   bus_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= B_IDLE;
         rdata_o <= '0;
      end else begin
         unique case (st)
            B_IDLE: if (req) st <= B_ADDR;
            B_ADDR: if (reg_ready) st <= wr_i ? B_ACK : B_RDW;
            B_RDW: begin
               if (reg_rvalid) begin
                  rdata_o <= reg_rdata;
                  st      <= B_ACK;
               end
            end
            B_ACK:   st <= B_IDLE;
            default: st <= B_IDLE;
         endcase
      end
   end

   // the address and data come straight from the step decoder;
   // they stay stable because the step only advances on ack
   assign reg_valid = (st == B_ADDR);
   assign reg_write = wr_i;
   assign reg_addr  = addr_i;
   assign reg_wdata = wdata_i;
   assign ack       = (st == B_ACK);

endmodule

// File: rtl/sref_cal_window.sv
module sref_cal_window #(
   parameter int CODE_W = 3,
   localparam int N_CODES = 1 << CODE_W
) (
   input  logic [N_CODES-1:0] pass_map,
   output logic               found,
   output logic [CODE_W-1:0]  best
);

   logic [CODE_W:0]   cur_len;
   logic [CODE_W:0]   top_len;
   logic [CODE_W-1:0] top_end;

   // scan upward; a strict compare keeps the lower run on a tie
   always_comb begin
      cur_len = '0;
      top_len = '0;
      top_end = '0;
      for (int i = 0; i < N_CODES; i++) begin
         if (pass_map[i]) cur_len = cur_len + 1'b1;
         else             cur_len = '0;
         if (cur_len > top_len) begin
            top_len = cur_len;
            top_end = CODE_W'(i);
         end
      end
   end

   assign found = (top_len != '0);
   // centre = end - floor(len/2) gives the lower middle for even runs
   assign best  = top_end - top_len[CODE_W:1];

endmodule

// File: rtl/sref_cal_ctl.sv
module sref_cal_ctl
   import sref_cal_pkg::*;
#(
   parameter int CODE_W           = 3,
   parameter int ADDR_W           = 12,
   parameter int DATA_W           = 8,
   parameter int SETTLE_CYC       = 16,
   parameter bit LINK_RST_SUPPORT = 1'b1,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h060,
   parameter logic [ADDR_W-1:0] DLY_ADDR  = 12'h061,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 12'h06C,
   parameter logic [ADDR_W-1:0] LRST_ADDR = 12'h201,
   parameter logic [DATA_W-1:0] LRST_D0   = 8'h3E,
   parameter logic [DATA_W-1:0] LRST_D1   = 8'h3F,
   parameter logic [DATA_W-1:0] FLAG_CLR  = 8'h07,
   parameter logic [DATA_W-1:0] PROC_ON   = 8'h01,
   parameter int DIRTY_BIT   = 0,
   parameter int REALIGN_BIT = 2,
   parameter int SYNC_BIT    = 3,
   localparam int N_CODES = 1 << CODE_W,
   localparam int CNT_W   = $clog2(SETTLE_CYC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               link_rst_en,
   output logic               reg_valid,
   input  logic               reg_ready,
   output logic               reg_write,
   output logic [ADDR_W-1:0]  reg_addr,
   output logic [DATA_W-1:0]  reg_wdata,
   input  logic               reg_rvalid,
   input  logic [DATA_W-1:0]  reg_rdata,
   output logic               busy,
   output logic               done,
   output logic               no_good,
   output logic               link_en,
   output logic [CODE_W-1:0]  chosen_code,
   output logic [N_CODES-1:0] pass_map
);

   // elaboration checks
   if (CODE_W < 1 || CODE_W > 6) begin : g_bad_code_w
      $error("sref_cal_ctl: CODE_W must be 1..6");
   end
   if (DATA_W < 8 || DATA_W < CODE_W) begin : g_bad_data_w
      $error("sref_cal_ctl: DATA_W too narrow");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("sref_cal_ctl: SETTLE_CYC must be at least 1");
   end
   if (DIRTY_BIT >= DATA_W || REALIGN_BIT >= DATA_W || SYNC_BIT >= DATA_W) begin : g_bad_bits
      $error("sref_cal_ctl: flag bit outside data word");
   end

   // variant: link-core reset trials present or stripped
   logic mode_req;
   if (LINK_RST_SUPPORT) begin : g_lrst
      assign mode_req = link_rst_en;
   end else begin : g_no_lrst
      logic unused_mode;
      assign unused_mode = link_rst_en;
      assign mode_req    = 1'b0;
   end

   ctl_e               state;
   step_e              step;
   logic [CODE_W-1:0]  code_q;
   logic [CODE_W-1:0]  fin_q;
   logic               mode_q;
   logic               found_q;
   logic [N_CODES-1:0] pass_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               done_q, err_q, link_q;

   logic               acc_wr, ack;
   logic [ADDR_W-1:0]  acc_addr;
   logic [DATA_W-1:0]  acc_wdata;
   logic [DATA_W-1:0]  rd_q;
   logic               win_found;
   logic [CODE_W-1:0]  win_best;
   logic               trial_fail;

   sref_cal_step #(
      .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CTRL_ADDR(CTRL_ADDR), .DLY_ADDR(DLY_ADDR), .FLAG_ADDR(FLAG_ADDR),
      .LRST_ADDR(LRST_ADDR), .LRST_D0(LRST_D0), .LRST_D1(LRST_D1),
      .FLAG_CLR(FLAG_CLR), .PROC_ON(PROC_ON)
   ) u_step (
      .step(step), .trial_code(code_q), .final_code(fin_q),
      .wr(acc_wr), .addr(acc_addr), .wdata(acc_wdata)
   );

   sref_cal_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
      .clk(clk), .rst_n(rst_n), .req(state == C_ACC),
      .wr_i(acc_wr), .addr_i(acc_addr), .wdata_i(acc_wdata),
      .ack(ack), .rdata_o(rd_q),
      .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata)
   );

   sref_cal_window #(.CODE_W(CODE_W)) u_win (
      .pass_map(pass_q), .found(win_found), .best(win_best)
   );

   logic unused_rd;
   assign unused_rd = ^rd_q;

   assign trial_fail = rd_q[DIRTY_BIT] |
                       (mode_q & (rd_q[REALIGN_BIT] | rd_q[SYNC_BIT]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= C_IDLE;
         step    <= ST_OFF;
         code_q  <= '0;
         fin_q   <= '0;
         mode_q  <= 1'b0;
         found_q <= 1'b0;
         pass_q  <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         link_q  <= 1'b0;
      end else begin
         unique case (state)
            C_IDLE, C_DONE: begin
               if (start) begin
                  pass_q  <= '0;
                  code_q  <= '0;
                  fin_q   <= '0;
                  found_q <= 1'b0;
                  step    <= ST_OFF;
                  mode_q  <= mode_req;
                  done_q  <= 1'b0;
                  err_q   <= 1'b0;
                  link_q  <= 1'b0;
                  state   <= C_ACC;
               end
            end
            C_ACC: begin
               if (ack) begin
                  unique case (step)
                     ST_OFF:  step <= ST_DLY;
                     ST_DLY:  step <= mode_q ? ST_RST0 : ST_CLR;
                     ST_RST0: step <= ST_RST1;
                     ST_RST1: step <= ST_CLR;
                     ST_CLR:  step <= ST_ON;
                     ST_ON: begin
                        cnt_q <= '0;
                        state <= C_SETTLE;
                     end
                     ST_RD: begin
                        pass_q[code_q] <= ~trial_fail;
                        step           <= ST_OFF;
                        if (&code_q) state  <= C_PICK;
                        else         code_q <= code_q + 1'b1;
                     end
                     ST_FOFF: step <= ST_FDLY;
                     ST_FDLY: step <= ST_FON;
                     ST_FON: begin
                        state  <= C_DONE;
                        done_q <= 1'b1;
                        link_q <= found_q;
                        err_q  <= ~found_q;
                     end
                     default: step <= ST_OFF;
                  endcase
               end
            end
            C_SETTLE: begin
               if (cnt_q == CNT_W'(SETTLE_CYC - 1)) begin
                  step  <= ST_RD;
                  state <= C_ACC;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            C_PICK: begin
               found_q <= win_found;
               fin_q   <= win_found ? win_best : '0;
               step    <= ST_FOFF;
               state   <= C_ACC;
            end
            default: state <= C_IDLE;
         endcase
      end
   end

   assign busy        = (state == C_ACC) || (state == C_SETTLE) || (state == C_PICK);
   assign done        = done_q;
   assign no_good     = err_q;
   assign link_en     = link_q;
   assign chosen_code = fin_q;
   assign pass_map    = pass_q;

endmodule

// File: rtl/sref_cal_chk.sv
module sref_cal_chk #(
   parameter int CODE_W     = 3,
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter int SETTLE_CYC = 16,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h060,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 12'h06C,
   parameter logic [DATA_W-1:0] PROC_ON   = 8'h01,
   localparam int N_CODES = 1 << CODE_W,
   localparam int GAP_W   = $clog2(SETTLE_CYC + 4) + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               reg_valid,
   input logic               reg_ready,
   input logic               reg_write,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic               busy,
   input logic               done,
   input logic               no_good,
   input logic               link_en,
   input logic [CODE_W-1:0]  chosen_code,
   input logic [N_CODES-1:0] pass_map
);

   // cycles since the last processing-on write handshake, saturating
   logic [GAP_W-1:0] gap_q;
   logic             on_hs;
   assign on_hs = reg_valid && reg_ready && reg_write &&
                  (reg_addr == CTRL_ADDR) && (reg_wdata == PROC_ON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         gap_q <= '1;
      else if (on_hs)     gap_q <= '0;
      else if (gap_q != '1) gap_q <= gap_q + 1'b1;
   end

   // R11
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_addr) &&
                                     $stable(reg_wdata) && $stable(reg_write)));

   // R3
   settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && !reg_write && (reg_addr == FLAG_ADDR)) |->
         (gap_q >= GAP_W'(SETTLE_CYC)));

   // R7
   link_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_en |-> (done && !busy && !reg_valid));

   // R8
   err_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      no_good |-> (!link_en && chosen_code == '0));

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R5
   map_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(pass_map));

endmodule

bind sref_cal_ctl sref_cal_chk #(
   .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .SETTLE_CYC(SETTLE_CYC), .CTRL_ADDR(CTRL_ADDR),
   .FLAG_ADDR(FLAG_ADDR), .PROC_ON(PROC_ON)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start),
   .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .busy(busy), .done(done), .no_good(no_good), .link_en(link_en),
   .chosen_code(chosen_code), .pass_map(pass_map)
);

// File: tb/sref_cal_ctl_test.sv
module sref_cal_ctl_test;

   localparam int SETTLE = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        link_rst_en = 1'b0;
   logic        reg_valid, reg_write;
   logic        reg_ready = 1'b0;
   logic        reg_rvalid = 1'b0;
   logic [11:0] reg_addr;
   logic [7:0]  reg_wdata;
   logic [7:0]  reg_rdata = 8'h00;
   logic        busy, done, no_good, link_en;
   logic [2:0]  chosen_code;
   logic [7:0]  pass_map;

   always #5 clk = ~clk;

   sref_cal_ctl uut (
      .clk(clk), .rst_n(rst_n), .start(start), .link_rst_en(link_rst_en),
      .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
      .busy(busy), .done(done), .no_good(no_good), .link_en(link_en),
      .chosen_code(chosen_code), .pass_map(pass_map)
   );

   typedef struct packed {
      logic       mode;
      logic [7:0] bad;
      logic [7:0] rmask;
      logic [7:0] smask;
      logic [7:0] exp_pass;
      logic [2:0] exp_code;
      logic       exp_err;
   } vec_t;

   localparam vec_t VECS [11] = '{
      '{1'b0, 8'h00, 8'h00, 8'h00, 8'hFF, 3'd3, 1'b0},
      '{1'b0, 8'h1C, 8'h00, 8'h00, 8'hE3, 3'd6, 1'b0},
      '{1'b0, 8'h81, 8'h00, 8'h00, 8'h7E, 3'd3, 1'b0},
      '{1'b0, 8'h10, 8'h00, 8'h00, 8'hEF, 3'd1, 1'b0},
      '{1'b0, 8'h18, 8'h00, 8'h00, 8'hE7, 3'd1, 1'b0},
      '{1'b0, 8'h00, 8'h0F, 8'hC0, 8'hFF, 3'd3, 1'b0},
      '{1'b1, 8'h00, 8'h0F, 8'hC0, 8'h30, 3'd4, 1'b0},
      '{1'b1, 8'h02, 8'h40, 8'h00, 8'hBD, 3'd3, 1'b0},
      '{1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 3'd0, 1'b1},
      '{1'b0, 8'h3C, 8'h00, 8'h00, 8'hC3, 3'd0, 1'b0},
      '{1'b0, 8'hEF, 8'h00, 8'h00, 8'h10, 3'd4, 1'b0}
   };

   int checks = 0;
   int fails  = 0;

   // converter model state
   logic [7:0] m_bad = 8'h00, m_rmask = 8'h00, m_smask = 8'h00;
   logic       m_proc = 1'b0, m_dirty = 1'b0, m_realign = 1'b0;
   logic [2:0] m_dly = 3'd0;
   int seq_err = 0, settle_err = 0, link_viol = 0;
   int rst_writes = 0, on_writes = 0, rd_count = 0;
   int last_op = 0, cyc = 0, on_cyc = 0;
   logic        lat_w;
   logic [11:0] lat_a;
   logic [7:0]  lat_d;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_access();
      if (link_en) link_viol++;
      if (lat_w) begin
         if (lat_a == 12'h060 && lat_d == 8'h00) begin
            if (last_op != 0 && last_op != 7) seq_err++;
            m_proc = 1'b0; last_op = 1;
         end else if (lat_a == 12'h060 && lat_d == 8'h01) begin
            if (last_op != 5 && last_op != 2) seq_err++;
            m_proc = 1'b1; last_op = 6; on_writes++; on_cyc = cyc;
            if (m_bad[m_dly])   m_dirty = 1'b1;
            if (m_rmask[m_dly]) m_realign = 1'b1;
         end else if (lat_a == 12'h061) begin
            if (last_op != 1 || m_proc) seq_err++;
            m_dly = lat_d[2:0]; last_op = 2;
         end else if (lat_a == 12'h201 && lat_d == 8'h3E) begin
            if (last_op != 2) seq_err++;
            rst_writes++; last_op = 3;
         end else if (lat_a == 12'h201 && lat_d == 8'h3F) begin
            if (last_op != 3) seq_err++;
            rst_writes++; last_op = 4;
         end else if (lat_a == 12'h06C) begin
            if (last_op != 2 && last_op != 4) seq_err++;
            if (lat_d[0]) m_dirty = 1'b0;
            if (lat_d[2]) m_realign = 1'b0;
            last_op = 5;
         end else begin
            seq_err++;
         end
      end else begin
         if (lat_a != 12'h06C || last_op != 6) seq_err++;
         if (int'(m_dly) != rd_count) seq_err++;
         rd_count++;
         last_op = 7;
         reg_rdata  = {4'h0, m_smask[m_dly], m_realign, 1'b1, m_dirty};
         reg_rvalid = 1'b1;
      end
   endtask

   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (!rst_n) begin
            reg_ready  = 1'b0;
            reg_rvalid = 1'b0;
         end else begin
            if (reg_rvalid) reg_rvalid = 1'b0;
            if (reg_ready) begin
               reg_ready = 1'b0;
               model_access();
            end else if (reg_valid) begin
               lat_w = reg_write; lat_a = reg_addr; lat_d = reg_wdata;
               if (!reg_write && reg_addr == 12'h06C && cyc - on_cyc < SETTLE)
                  settle_err++;
               reg_ready = 1'b1;
            end
         end
      end
   end

   task automatic model_clear(input vec_t v);
      m_bad = v.bad; m_rmask = v.rmask; m_smask = v.smask;
      seq_err = 0; settle_err = 0; link_viol = 0;
      rst_writes = 0; on_writes = 0; rd_count = 0; last_op = 0;
      link_rst_en = v.mode;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (done) begin ok = 1'b1; break; end
      end
   endtask

   task automatic check_result(input vec_t v, input string tag);
      chk(pass_map == v.exp_pass, "R4 R5", {tag, " pass_map"}, pass_map, v.exp_pass);
      chk(chosen_code == v.exp_code, "R6", {tag, " chosen_code"}, chosen_code, v.exp_code);
      chk(no_good == v.exp_err, "R8", {tag, " no_good"}, no_good, v.exp_err);
      chk(link_en == !v.exp_err, "R7", {tag, " link_en"}, link_en, !v.exp_err);
      chk(m_dly == v.exp_code, "R7 R8", {tag, " final delay reg"}, m_dly, v.exp_code);
      chk(link_viol == 0, "R7", {tag, " link_en during access"}, link_viol, 0);
      chk(seq_err == 0, "R1", {tag, " access order"}, seq_err, 0);
      chk(rst_writes == (v.mode ? 16 : 0), "R2", {tag, " link reset writes"},
          rst_writes, v.mode ? 16 : 0);
      chk(settle_err == 0, "R3", {tag, " settle gap"}, settle_err, 0);
      chk(rd_count == 8 && on_writes == 9, "R5", {tag, " trial count"}, rd_count, 8);
      chk(!busy, "R9", {tag, " busy at done"}, busy, 0);
   endtask

   bit timed_out = 1'b0;

   initial begin
      repeat (150000) @(posedge clk);
      timed_out = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      bit ok;
      vec_t v;
      // R10 reset state
      repeat (3) @(negedge clk);
      chk({busy, done, no_good, link_en, reg_valid} == 5'b0, "R10", "reset outputs",
          {busy, done, no_good, link_en, reg_valid}, 0);
      chk(chosen_code == 3'd0 && pass_map == 8'h00, "R10", "reset result",
          pass_map, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int k = 0; k < 11; k++) begin
         v = VECS[k];
         model_clear(v);
         pulse_start();
         chk(busy == 1'b1, "R9", $sformatf("vec%0d busy after start", k), busy, 1);
         wait_done(ok);
         chk(ok, "R9", $sformatf("vec%0d done reached", k), ok, 1);
         check_result(v, $sformatf("vec%0d", k));
      end

      // R9: start while busy ignored; R2: mode change mid-run ignored
      v = VECS[1];
      model_clear(v);
      pulse_start();
      repeat (100) @(negedge clk);
      link_rst_en = 1'b1;
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_done(ok);
      chk(ok, "R9", "restart-ignored done", ok, 1);
      check_result(v, "busy-start");

      // R9: start from done clears the map at once
      v = VECS[0];
      model_clear(v);
      pulse_start();
      chk(pass_map == 8'h00 && !done && !link_en, "R9", "map cleared on rerun",
          pass_map, 0);
      wait_done(ok);
      check_result(v, "rerun");

      // R10: reset in mid-run returns to idle state
      model_clear(VECS[2]);
      pulse_start();
      repeat (60) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk({busy, done, no_good, link_en, reg_valid} == 5'b0 && pass_map == 8'h00,
          "R10", "mid-run reset", {busy, done, link_en, reg_valid}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(!busy && !reg_valid, "R10", "idle after reset", busy, 0);

      if (!timed_out) begin
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule